// File: doc/BRIEF.md
# Exception Frame Stacking Unit

This unit performs the hardware context save and restore that a small 32-bit microcontroller core carries out around an exception. When an exception is taken, the core hands over the live values of R0-R3, R12, LR, the return address and the status word, together with both stack pointers and the current mode. The unit writes an eight-word frame below the active stack pointer, one word per transfer over a valid/ready memory port. It reports the new stack pointer and a magic link value of the form 0xFFFFFFFx, and the core loads both.

When the core later branches to one of those magic values, it passes the branch target to the unit. The unit decodes the low nibble to find the target mode and the stack that holds the frame. It reads the eight words back in ascending address order and returns them with the raised stack pointer. An undefined nibble raises a one-cycle fault and touches no memory. The frame always begins on an 8-byte boundary. If the pre-exception pointer is only word aligned, a zero padding word is pushed above the status word. The unit records this in bit 9 of the stacked status word, and it reads that bit on return to decide how far to raise the pointer.

The sequencer has six states. IDLE accepts requests. PUSH_PAD writes the padding word. PUSH writes the frame, highest slot first. POP reads the frame, lowest slot first. DONE is a one-cycle result state. FAULT is a one-cycle state that reports a rejected code. The transitions are these:
- An entry request in IDLE moves to PUSH_PAD or to PUSH.
- A valid return code in IDLE moves to POP.
- An undefined code in IDLE moves to FAULT.
- PUSH_PAD moves to PUSH on its handshake.
- PUSH moves to DONE after the slot-0 handshake.
- POP moves to DONE after the last slot's handshake.
- DONE and FAULT both return to IDLE.

Top module: `exc_frame_unit`

## Requirements
- R1: Frame slot k sits at frame pointer + 4k, and slot k of `cur_words`/`rest_words` is bits [32k+31:32k]. The slot order is R0, R1, R2, R3, R12, LR, return address, status word (slots 0..7). Every memory address is word aligned.
- R2: On entry, the active pointer is chosen as follows: handler mode uses the main pointer; thread mode uses the process pointer when `cur_use_psp`=1 and the main pointer otherwise. If bit 2 of that pointer is 0, the frame pointer is the pointer minus 32 and exactly 8 words are written. `upd_sp_val` gives the frame pointer when `done` is high, and `upd_sp_sel` marks the chosen pointer (0 main, 1 process).
- R3: If bit 2 of the active pointer is 1, a zero word is first written at pointer minus 4, and the frame pointer is the pointer minus 36. Bit 9 of the stacked status word is replaced by 1 when padding was inserted and by 0 when it was not.
- R4: Entry writes go in descending address order: the padding word (if any), then slot 7 down to slot 0. The stacked return address has bit 0 cleared.
- R5: On entry, `upd_lr_val` is 0xFFFFFFF1 for handler mode, 0xFFFFFFF9 for thread mode on the main pointer, and 0xFFFFFFFD for thread mode on the process pointer. `upd_lr_en` is high only in the `done` cycle of an entry.
- R6: A `ret_req` whose target has bits 31:4 all ones and a low nibble of 1, 9 or D starts a return. The frame is read from the main pointer for 1 and 9, and from the process pointer for D. The reads go in ascending order from slot 0 to slot 7. In the `done` cycle, `rest_valid`=1, `rest_words` holds the read words, and `rest_handler`/`rest_use_psp` give the target mode (1/0, 0/0, 0/1 respectively).
- R7: On return, `upd_sp_val` is the frame pointer plus 36 if bit 9 of the stacked status word is 1, and plus 32 otherwise. The status word in `rest_words` has bit 9 cleared.
- R8: A `ret_req` whose target has bits 31:4 all ones and any other nibble raises `fault` for exactly the next cycle. It makes no memory access and does not raise `done`.
- R9: A memory request holds its address, data and direction until `mem_ready`. `busy` is high from the cycle after the request until the last handshake. `done` is high for exactly the one cycle after that, with `busy` low.
- R10: `entry_req` and `ret_req` are ignored while `busy` or `done` is high. A `ret_req` whose target is not of the form 0xFFFFFFFx is ignored. If `entry_req` and `ret_req` arrive together in IDLE, the entry wins.
- R11: After reset, `busy`, `done`, `fault` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_req | input | 1 | Start stacking (one-cycle pulse) |
| cur_words | input | 256 | Live register values, slot k at bits [32k+31:32k] |
| cur_handler | input | 1 | Interrupted context was handler mode |
| cur_use_psp | input | 1 | Thread context was using the process pointer |
| msp_in | input | 32 | Current main stack pointer |
| psp_in | input | 32 | Current process stack pointer |
| ret_req | input | 1 | Branch-to-target notice (one-cycle pulse) |
| ret_target | input | 32 | Branch target value |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request (read data valid in the same cycle) |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Transfer sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle undefined-return-code pulse |
| upd_sp_sel | output | 1 | Pointer to update: 0 main, 1 process |
| upd_sp_val | output | 32 | New pointer value, valid while done |
| upd_lr_en | output | 1 | Load LR with upd_lr_val (entry done) |
| upd_lr_val | output | 32 | Magic return code |
| rest_valid | output | 1 | Restored words valid (return done) |
| rest_words | output | 256 | Restored slots, same layout as cur_words |
| rest_handler | output | 1 | Restored mode is handler |
| rest_use_psp | output | 1 | Restored thread uses the process pointer |

## Verification
The hardest situation to reach is a request that arrives while a frame transfer is stalled part way through. Both an extra entry and a return code must then leave no trace in the memory traffic or the results. The bench holds a pseudo-random `mem_ready` pattern and injects both pulses a few cycles into a stalled push. It then compares the logged write count, the read count and the reported pointer with the values of the first request alone. The padded frame path is reached with pointers whose bit 2 is set. The padding flag is checked twice: once through the stacked status word, and again through the pointer reported on the matching return.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PUSH_PAD = 3'd1,
        S_PUSH     = 3'd2,
        S_POP      = 3'd3,
        S_DONE     = 3'd4,
        S_FAULT    = 3'd5
    } seq_state_e;

    // Meaning of a return code
    typedef enum logic [1:0] {
        RET_HND_MAIN = 2'd0,
        RET_THR_MAIN = 2'd1,
        RET_THR_PROC = 2'd2,
        RET_BAD      = 2'd3
    } ret_kind_e;

    localparam logic [3:0] NIB_HND_MAIN = 4'h1;
    localparam logic [3:0] NIB_THR_MAIN = 4'h9;
    localparam logic [3:0] NIB_THR_PROC = 4'hD;

endpackage

// File: rtl/exc_code_unit.sv
module exc_code_unit
    import exc_frame_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] ret_target,
    input  logic          cur_handler,
    input  logic          cur_use_psp,
    output logic          is_magic,
    output ret_kind_e     kind,
    output logic [DW-1:0] entry_code
);

    logic [3:0] entry_nib;

    assign is_magic = &ret_target[DW-1:4];

    always_comb begin
        unique case (ret_target[3:0])
            NIB_HND_MAIN: kind = RET_HND_MAIN;
            NIB_THR_MAIN: kind = RET_THR_MAIN;
            NIB_THR_PROC: kind = RET_THR_PROC;
            default:      kind = RET_BAD;
        endcase
    end

    always_comb begin
        if (cur_handler)      entry_nib = NIB_HND_MAIN;
        else if (cur_use_psp) entry_nib = NIB_THR_PROC;
        else                  entry_nib = NIB_THR_MAIN;
    end

    assign entry_code = {{(DW-4){1'b1}}, entry_nib};

endmodule

// File: rtl/frame_addr_gen.sv
module frame_addr_gen #(
    parameter int DW     = 32,
    parameter int NWORDS = 8
) (
    input  logic [DW-1:0] sp_entry,
    output logic [DW-1:0] fp_entry,
    output logic          pad_entry,
    input  logic [DW-1:0] pop_fp,
    input  logic          pop_pad,
    output logic [DW-1:0] pop_sp
);

    localparam logic [DW-1:0] FRAME_BYTES = DW'(NWORDS * 4);
    localparam logic [DW-1:0] WORD_BYTES  = DW'(4);

    logic [DW-1:0] raw_fp;

    // Frame start is rounded down to an 8-byte boundary
    assign raw_fp    = sp_entry - FRAME_BYTES;
    assign fp_entry  = {raw_fp[DW-1:3], 3'b000};
    assign pad_entry = sp_entry[2];

    assign pop_sp = pop_fp + FRAME_BYTES + (pop_pad ? WORD_BYTES : '0);

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import exc_frame_pkg::*;
#(
    parameter int NWORDS = 8,
    parameter int IW     = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_push,
    input  logic          go_pop,
    input  logic          go_fault,
    input  logic          with_pad,
    input  logic          mem_ready,
    output seq_state_e    state,
    output logic [IW-1:0] slot,
    output logic          mem_valid,
    output logic          mem_write,
    output logic          busy,
    output logic          done,
    output logic          fault
);

    localparam logic [IW-1:0] TOP_SLOT = IW'(NWORDS - 1);

    seq_state_e    state_q, state_d;
    logic [IW-1:0] slot_q, slot_d;
    logic          hs;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Next state and slot
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            S_IDLE: begin
                if (go_push) begin
                    state_d = with_pad ? S_PUSH_PAD : S_PUSH;
                    slot_d  = TOP_SLOT;
                end else if (go_pop) begin
                    state_d = S_POP;
                    slot_d  = '0;
                end else if (go_fault) begin
                    state_d = S_FAULT;
                end
            end
            S_PUSH_PAD: begin
                if (hs) state_d = S_PUSH;
            end
            S_PUSH: begin
                if (hs) begin
                    if (slot_q == '0) state_d = S_DONE;
                    else              slot_d  = slot_q - 1'b1;
                end
            end
            S_POP: begin
                if (hs) begin
                    if (slot_q == TOP_SLOT) state_d = S_DONE;
                    else                    slot_d  = slot_q + 1'b1;
                end
            end
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        done      = 1'b0;
        fault     = 1'b0;
        unique case (state_q)
            S_PUSH_PAD, S_PUSH: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
            end
            S_POP:   mem_valid = 1'b1;
            S_DONE:  done      = 1'b1;
            S_FAULT: fault     = 1'b1;
            default: ;
        endcase
    end

    assign hs    = mem_valid & mem_ready;
    assign busy  = mem_valid;
    assign state = state_q;
    assign slot  = slot_q;

    // R9
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(state_q) && $stable(slot_q)));

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/exc_frame_unit.sv
module exc_frame_unit
    import exc_frame_pkg::*;
#(
    parameter int DW        = 32,
    parameter int NWORDS    = 8,
    parameter int RA_SLOT   = 6,
    parameter int STAT_SLOT = 7,
    parameter int ALIGN_BIT = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 entry_req,
    input  logic [NWORDS*DW-1:0] cur_words,
    input  logic                 cur_handler,
    input  logic                 cur_use_psp,
    input  logic [DW-1:0]        msp_in,
    input  logic [DW-1:0]        psp_in,
    input  logic                 ret_req,
    input  logic [DW-1:0]        ret_target,
    output logic                 mem_valid,
    output logic                 mem_write,
    output logic [DW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic                 mem_ready,
    input  logic [DW-1:0]        mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 fault,
    output logic                 upd_sp_sel,
    output logic [DW-1:0]        upd_sp_val,
    output logic                 upd_lr_en,
    output logic [DW-1:0]        upd_lr_val,
    output logic                 rest_valid,
    output logic [NWORDS*DW-1:0] rest_words,
    output logic                 rest_handler,
    output logic                 rest_use_psp
);

    localparam int              IW          = $clog2(NWORDS);
    localparam logic [DW-1:0]   FRAME_BYTES = DW'(NWORDS * 4);

    seq_state_e                 st;
    logic [IW-1:0]              slot;
    logic                       is_magic;
    ret_kind_e                  kind;
    logic [DW-1:0]              entry_code;
    logic                       idle, go_push, go_pop, go_fault;
    logic [DW-1:0]              entry_sp, ret_sp, fp_entry, pop_sp;
    logic                       pad_entry;
    logic [NWORDS-1:0][DW-1:0]  ent_w, words_q, rest_w;
    logic [DW-1:0]              fp_q, lr_q;
    logic                       entry_q, sel_psp_q, hnd_q;

    exc_code_unit #(.DW(DW)) u_code (
        .ret_target  (ret_target),
        .cur_handler (cur_handler),
        .cur_use_psp (cur_use_psp),
        .is_magic    (is_magic),
        .kind        (kind),
        .entry_code  (entry_code)
    );

    assign entry_sp = (!cur_handler && cur_use_psp) ? psp_in : msp_in;
    assign ret_sp   = (kind == RET_THR_PROC) ? psp_in : msp_in;

    frame_addr_gen #(.DW(DW), .NWORDS(NWORDS)) u_addr (
        .sp_entry  (entry_sp),
        .fp_entry  (fp_entry),
        .pad_entry (pad_entry),
        .pop_fp    (fp_q),
        .pop_pad   (words_q[STAT_SLOT][ALIGN_BIT]),
        .pop_sp    (pop_sp)
    );

    assign idle     = (st == S_IDLE);
    assign go_push  = idle & entry_req;
    assign go_pop   = idle & !entry_req & ret_req & is_magic & (kind != RET_BAD);
    assign go_fault = idle & !entry_req & ret_req & is_magic & (kind == RET_BAD);

    frame_seq #(.NWORDS(NWORDS), .IW(IW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_push   (go_push),
        .go_pop    (go_pop),
        .go_fault  (go_fault),
        .with_pad  (pad_entry),
        .mem_ready (mem_ready),
        .state     (st),
        .slot      (slot),
        .mem_valid (mem_valid),
        .mem_write (mem_write),
        .busy      (busy),
        .done      (done),
        .fault     (fault)
    );

    // Entry frame: return address bit 0 cleared, status alignment bit replaced
    always_comb begin
        ent_w                       = cur_words;
        ent_w[RA_SLOT][0]           = 1'b0;
        ent_w[STAT_SLOT][ALIGN_BIT] = pad_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q   <= '0;
            fp_q      <= '0;
            lr_q      <= '0;
            entry_q   <= 1'b0;
            sel_psp_q <= 1'b0;
            hnd_q     <= 1'b0;
        end else begin
            if (go_push) begin
                words_q   <= ent_w;
                fp_q      <= fp_entry;
                lr_q      <= entry_code;
                entry_q   <= 1'b1;
                sel_psp_q <= !cur_handler && cur_use_psp;
            end else if (go_pop) begin
                fp_q      <= ret_sp;
                entry_q   <= 1'b0;
                sel_psp_q <= (kind == RET_THR_PROC);
                hnd_q     <= (kind == RET_HND_MAIN);
            end
            if (st == S_POP && mem_ready) begin
                words_q[slot] <= mem_rdata;
            end
        end
    end

    always_comb begin
        if (st == S_PUSH_PAD) begin
            mem_addr  = fp_q + FRAME_BYTES;
            mem_wdata = '0;
        end else begin
            mem_addr  = fp_q + {{(DW-IW-2){1'b0}}, slot, 2'b00};
            mem_wdata = words_q[slot];
        end
    end

    always_comb begin
        rest_w                       = words_q;
        rest_w[STAT_SLOT][ALIGN_BIT] = 1'b0;
    end

    assign upd_sp_sel   = sel_psp_q;
    assign upd_sp_val   = entry_q ? fp_q : pop_sp;
    assign upd_lr_en    = done & entry_q;
    assign upd_lr_val   = lr_q;
    assign rest_valid   = done & !entry_q;
    assign rest_words   = rest_w;
    assign rest_handler = hnd_q;
    assign rest_use_psp = sel_psp_q;

    // R1
    addr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    // R2
    frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_lr_en |-> (upd_sp_val[2:0] == 3'b000));

    // R5
    lr_magic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_lr_en |-> (&upd_lr_val[DW-1:4]));

    // R7
    status_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rest_valid |-> !rest_words[STAT_SLOT*DW + ALIGN_BIT]);

    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_valid && !done));

    // R9
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_write)));

endmodule

// File: tb/sim_exc_frame_unit.sv
module sim_exc_frame_unit;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         entry_req, cur_handler, cur_use_psp, ret_req;
    logic [255:0] cur_words;
    logic [31:0]  msp_in, psp_in, ret_target;
    logic         mem_valid, mem_write, mem_ready;
    logic [31:0]  mem_addr, mem_wdata, mem_rdata;
    logic         busy, done, fault;
    logic         upd_sp_sel, upd_lr_en, rest_valid, rest_handler, rest_use_psp;
    logic [31:0]  upd_sp_val, upd_lr_val;
    logic [255:0] rest_words;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_frame_unit u0 (
        .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .cur_words(cur_words),
        .cur_handler(cur_handler), .cur_use_psp(cur_use_psp), .msp_in(msp_in),
        .psp_in(psp_in), .ret_req(ret_req), .ret_target(ret_target),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault), .upd_sp_sel(upd_sp_sel),
        .upd_sp_val(upd_sp_val), .upd_lr_en(upd_lr_en), .upd_lr_val(upd_lr_val),
        .rest_valid(rest_valid), .rest_words(rest_words),
        .rest_handler(rest_handler), .rest_use_psp(rest_use_psp)
    );

    // Memory model with optional pseudo-random stalls
    logic [31:0] mem [256];
    logic [31:0] wlog [128];
    logic [31:0] wdlog [128];
    logic [31:0] rlog [128];
    int          wcnt = 0;
    int          rcnt = 0;
    logic [7:0]  lfsr = 8'h5A;
    logic        stall_en = 1'b0;

    assign mem_ready = stall_en ? lfsr[0] : 1'b1;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                wlog[wcnt]  <= mem_addr;
                wdlog[wcnt] <= mem_wdata;
                wcnt <= wcnt + 1;
            end else begin
                rlog[rcnt] <= mem_addr;
                rcnt <= rcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        summary();
        $finish;
    end

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            if (done) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic pulse_entry();
        entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
    endtask

    task automatic pulse_ret(input logic [31:0] tgt);
        ret_target = tgt;
        ret_req    = 1'b1;
        @(negedge clk);
        ret_req    = 1'b0;
    endtask

    // sp[34:3], handler[2], use_psp[1], stall[0]
    localparam logic [34:0] VEC [4] = '{
        {32'h2000_0200, 1'b0, 1'b0, 1'b0},
        {32'h2000_02F4, 1'b0, 1'b1, 1'b1},
        {32'h2000_0300, 1'b1, 1'b1, 1'b1},
        {32'h2000_01FC, 1'b1, 1'b0, 1'b0}
    };

    initial begin
        bit          ok, okw;
        logic [31:0] sp, fp, code, w [8], stk [8], rst_exp [8];
        logic        hnd, psp, pad, sel;
        int          wb, rb, bcnt;

        rst_n = 1'b0; entry_req = 1'b0; ret_req = 1'b0; cur_handler = 1'b0;
        cur_use_psp = 1'b0; cur_words = '0; msp_in = '0; psp_in = '0; ret_target = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !fault && !mem_valid, "R11 reset outputs",
            {28'd0, busy, done, fault, mem_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven entry/return pairs
        for (int i = 0; i < 4; i++) begin
            sp  = VEC[i][34:3];
            hnd = VEC[i][2];
            psp = VEC[i][1];
            stall_en = VEC[i][0];
            pad = sp[2];
            sel = !hnd && psp;
            fp  = pad ? sp - 32'd36 : sp - 32'd32;
            code = hnd ? 32'hFFFF_FFF1 : (psp ? 32'hFFFF_FFFD : 32'hFFFF_FFF9);
            for (int k = 0; k < 8; k++) begin
                w[k] = 32'h0800_0001 + 32'(i) * 32'h100 + 32'(k) * 32'h11_0000;
                cur_words[32*k +: 32] = w[k];
                stk[k] = w[k];
                rst_exp[k] = w[k];
            end
            stk[6][0] = 1'b0;
            stk[7][9] = pad;
            rst_exp[6][0] = 1'b0;
            rst_exp[7][9] = 1'b0;
            cur_handler = hnd;
            cur_use_psp = psp;
            msp_in = sel ? 32'h2000_0390 : sp;
            psp_in = sel ? sp : 32'h2000_0390;
            wb = wcnt;
            pulse_entry();
            wait_done(ok);
            chk(ok, "R9 entry done reached", {31'd0, ok}, 32'd1);
            chk(upd_sp_val == fp, pad ? "R3 padded frame pointer" : "R2 frame pointer", upd_sp_val, fp);
            chk(upd_sp_sel == sel, "R2 pointer select", {31'd0, upd_sp_sel}, {31'd0, sel});
            chk(upd_lr_en && upd_lr_val == code, "R5 magic LR code", upd_lr_val, code);
            chk(!rest_valid, "R5 no restore on entry", {31'd0, rest_valid}, 32'd0);
            @(negedge clk);
            chk(wcnt - wb == 8 + int'(pad), "R2 write count", 32'(wcnt - wb), 32'(8 + int'(pad)));
            okw = 1'b1;
            for (int k = 0; k < 8; k++) if (mem[(fp[9:2]) + 8'(k)] !== stk[k]) okw = 1'b0;
            chk(okw, "R1 frame contents and layout", mem[fp[9:2] + 8'd7], stk[7]);
            chk(mem[fp[9:2] + 8'd6][0] == 1'b0 && mem[fp[9:2] + 8'd7][9] == pad,
                "R3 status flag and R4 return address bit 0", mem[fp[9:2] + 8'd7], stk[7]);
            if (pad) begin
                chk(wlog[wb] == sp - 32'd4 && wdlog[wb] == 32'd0, "R3 padding word first and zero",
                    wlog[wb], sp - 32'd4);
            end
            okw = 1'b1;
            for (int j = 0; j < 8; j++)
                if (wlog[wb + int'(pad) + j] !== fp + 32'd28 - 32'(j) * 32'd4) okw = 1'b0;
            chk(okw, "R4 descending write order", wlog[wb + int'(pad)], fp + 32'd28);

            // Matching return
            if (sel) psp_in = fp; else msp_in = fp;
            rb = rcnt;
            pulse_ret(code);
            wait_done(ok);
            chk(ok && rest_valid && !upd_lr_en, "R6 return done", {30'd0, rest_valid, upd_lr_en}, 32'd2);
            okw = 1'b1;
            for (int k = 0; k < 8; k++) if (rest_words[32*k +: 32] !== rst_exp[k]) okw = 1'b0;
            chk(okw, "R6 restored words", rest_words[255:224], rst_exp[7]);
            chk(upd_sp_val == sp, "R7 pointer raised by frame size", upd_sp_val, sp);
            chk(rest_handler == hnd && rest_use_psp == sel && upd_sp_sel == sel, "R6 restored mode",
                {29'd0, rest_handler, rest_use_psp, upd_sp_sel}, {29'd0, hnd, sel, sel});
            @(negedge clk);
            chk(!done, "R9 done single cycle", {31'd0, done}, 32'd0);
            okw = (rcnt - rb == 8);
            for (int j = 0; j < 8; j++) if (rlog[rb + j] !== fp + 32'(j) * 32'd4) okw = 1'b0;
            chk(okw, "R6 ascending read order", 32'(rcnt - rb), 32'd8);
        end

        // R9 busy window, padded, no stalls: 9 busy cycles
        stall_en = 1'b0; cur_handler = 1'b0; cur_use_psp = 1'b0; msp_in = 32'h2000_0104;
        entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        bcnt = 0;
        for (int n = 0; n < 50; n++) begin
            if (done) break;
            if (busy) bcnt++;
            @(negedge clk);
        end
        chk(done && !busy && bcnt == 9, "R9 busy span then done", 32'(bcnt), 32'd9);
        @(negedge clk);

        // R8 undefined code
        wb = wcnt; rb = rcnt;
        pulse_ret(32'hFFFF_FFF5);
        chk(fault && !busy && !mem_valid, "R8 fault pulse", {31'd0, fault}, 32'd1);
        @(negedge clk);
        chk(!fault && !done && !busy, "R8 fault single cycle", {29'd0, fault, done, busy}, 32'd0);
        chk(wcnt == wb && rcnt == rb, "R8 no memory access", 32'(rcnt - rb), 32'd0);

        // R10 non-magic target ignored
        pulse_ret(32'h0800_005F);
        bcnt = 0;
        for (int n = 0; n < 4; n++) begin
            if (busy || done || fault) bcnt++;
            @(negedge clk);
        end
        chk(bcnt == 0 && rcnt == rb, "R10 plain branch ignored", 32'(bcnt), 32'd0);

        // R10 requests while busy ignored (stalled push)
        stall_en = 1'b1; msp_in = 32'h2000_0080; cur_handler = 1'b0; cur_use_psp = 1'b0;
        wb = wcnt; rb = rcnt;
        pulse_entry();
        @(negedge clk);
        msp_in = 32'h2000_0044;
        entry_req = 1'b1;
        pulse_ret(32'hFFFF_FFF9);
        entry_req = 1'b0;
        wait_done(ok);
        chk(ok && upd_sp_val == 32'h2000_0060, "R10 busy requests ignored", upd_sp_val, 32'h2000_0060);
        @(negedge clk);
        bcnt = 0;
        for (int n = 0; n < 4; n++) begin
            if (busy || done) bcnt++;
            @(negedge clk);
        end
        chk(wcnt - wb == 8 && rcnt == rb && bcnt == 0, "R10 no extra traffic",
            32'(wcnt - wb), 32'd8);

        // R10 simultaneous entry and return: entry wins
        stall_en = 1'b0; msp_in = 32'h2000_0040;
        wb = wcnt; rb = rcnt;
        entry_req = 1'b1;
        pulse_ret(32'hFFFF_FFF9);
        entry_req = 1'b0;
        wait_done(ok);
        chk(ok && upd_lr_en && rcnt == rb, "R10 entry has priority", {31'd0, upd_lr_en}, 32'd1);

        summary();
        $finish;
    end

endmodule